// File: doc/BRIEF.md
# Ring Coherence Home Controller

This block is the home node of a unidirectional ring of client caches that share one scratchpad address space. Clients keep their lines in one of four states: Modified, Owned, Shared or Invalid. The home node is the only point where requests are put in order. Every raw request from a client enters the home node first. The node stamps it with a global sequence number and sends it out as an ordered message. That message then travels past every client, so each one can snoop it, and it comes back to the home node at the end of the lap.

The node holds the backing word for every address and one owner bit per address. A clear owner bit means the home node owns the line, and in that case it attaches its stored word to an ordered read. A set owner bit means some client holds the line as M or O, and that client supplies the word as the message passes it. A read-exclusive moves ownership to the requester and sets the bit. A write-back stores the word and clears the bit.

While an ordered message for an address is still on its lap, a later request to the same address is parked in a one-entry hold slot. The parked request is issued after the lap completes.

Message type codes are 3 bits wide. Bit 2 set means an ordered message, and bit 2 clear means a raw client request. Bits 1:0 give the kind: 0 is read-shared, 1 is read-exclusive, 2 is write-back.

Top module: `ring_home_ctrl`

## Requirements
- R1: After reset, `out_valid` is low, every owner bit is clear, and every stored word is zero. The first request offered is accepted.
- R2: An accepted request leaves the block as an ordered message with the same address, source and kind, and with type bit 2 set. Ordered messages carry `out_seq` values 0, 1, 2 and so on, one per message, with wraparound.
- R3: An ordered read to an address whose owner bit is clear carries `out_dv`=1 and the stored word for that address.
- R4: An ordered read to an address whose owner bit is set carries `out_dv`=0 and a data word of zero.
- R5: Issuing a read-exclusive sets the owner bit of its address. Issuing a read-shared leaves the owner bit unchanged.
- R6: Issuing a write-back writes its data word into the store and clears the owner bit. The ordered write-back carries `out_dv`=0 and a data word of zero.
- R7: The home node does not issue a request while an ordered message to the same address is still on the ring, that is, issued but not yet returned. Such a request is parked instead. It is issued one cycle after the return is accepted, provided the output register is free at that point.
- R8: A returning ordered message is always accepted. While the hold slot is full, no raw request is accepted.
- R9: While `out_valid` is high and `out_ready` is low, every output field stays unchanged.
- R10: A raw request to an address that is not pending is refused while the output register is full and not draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Ring input message valid |
| in_ready | output | 1 | Ring input message taken |
| in_type | input | 3 | Message type: bit 2 = ordered, bits 1:0 = kind |
| in_addr | input | AW | Line address |
| in_src | input | SW | Requesting client ID |
| in_data | input | DW | Data word; used for write-backs |
| out_valid | output | 1 | Ordered message valid |
| out_ready | input | 1 | Next ring hop can take the message |
| out_type | output | 3 | Ordered message type |
| out_addr | output | AW | Line address |
| out_src | output | SW | Requesting client ID |
| out_seq | output | QW | Global order stamp |
| out_dv | output | 1 | Data attached by the home node |
| out_data | output | DW | Attached data word |

## Verification
The assertions take four things for granted about the inputs. Kind code 3 never appears. A message with type bit 2 set arrives only for an address that has a lap in flight. Each lap returns exactly once. The upstream station may swap a refused raw request for ring traffic, so that returning messages are never blocked behind a parked address.

The stimulus keeps within these rules by modelling the ring. Every ordered message taken at the output is queued and fed back after a delay of three to seven cycles. Fed-back messages take priority over waiting requests. Raw requests use only kinds 0 to 2, and their addresses are crowded onto a few lines so that conflicts and parking occur often.

// File: rtl/ring_home_ctrl.sv
`timescale 1ns/1ps
module ring_home_ctrl #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int SW = 3,
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_type,
  input  logic [AW-1:0] in_addr,
  input  logic [SW-1:0] in_src,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_type,
  output logic [AW-1:0] out_addr,
  output logic [SW-1:0] out_src,
  output logic [QW-1:0] out_seq,
  output logic          out_dv,
  output logic [DW-1:0] out_data
);
  localparam int LINES = 1 << AW;
  localparam logic [1:0] K_RDX = 2'd1;
  localparam logic [1:0] K_WB  = 2'd2;

  logic [DW-1:0]    store [LINES];
  logic [LINES-1:0] own, pend, pend_nx;
  logic             h_v;
  logic [1:0]       h_kind;
  logic [AW-1:0]    h_addr;
  logic [SW-1:0]    h_src;
  logic [DW-1:0]    h_data;
  logic [QW-1:0]    seq;

  logic is_ret, slot, hold_go, in_req, in_go, in_park, issue, ret_clr;
  logic [1:0]    i_kind;
  logic [AW-1:0] i_addr;
  logic [SW-1:0] i_src;
  logic [DW-1:0] i_data;

  assign is_ret   = in_type[2];
  assign slot     = !out_valid || out_ready;
  assign hold_go  = h_v && !pend[h_addr] && slot;
  assign in_req   = in_valid && !is_ret;
  assign in_go    = in_req && !h_v && !pend[in_addr] && slot;
  assign in_park  = in_req && !h_v && pend[in_addr];
  assign in_ready = is_ret || (!h_v && (pend[in_addr] || slot));
  assign issue    = hold_go || in_go;
  assign ret_clr  = in_valid && is_ret;

  assign i_kind = hold_go ? h_kind : in_type[1:0];
  assign i_addr = hold_go ? h_addr : in_addr;
  assign i_src  = hold_go ? h_src  : in_src;
  assign i_data = hold_go ? h_data : in_data;

  always_comb begin
    pend_nx = pend;
    if (ret_clr) pend_nx[in_addr] = 1'b0;
    if (issue)   pend_nx[i_addr]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      own  <= '0;
      seq  <= '0;
      for (int i = 0; i < LINES; i++) store[i] <= '0;
    end else begin
      pend <= pend_nx;
      if (issue) begin
        seq <= seq + 1'b1;
        if (i_kind == K_WB) begin
          store[i_addr] <= i_data;
          own[i_addr]   <= 1'b0;
        end else if (i_kind == K_RDX) begin
          own[i_addr] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_type  <= '0;
      out_addr  <= '0;
      out_src   <= '0;
      out_seq   <= '0;
      out_dv    <= 1'b0;
      out_data  <= '0;
    end else if (issue) begin
      out_valid <= 1'b1;
      out_type  <= {1'b1, i_kind};
      out_addr  <= i_addr;
      out_src   <= i_src;
      out_seq   <= seq;
      if (i_kind == K_WB || own[i_addr]) begin
        out_dv   <= 1'b0;
        out_data <= '0;
      end else begin
        out_dv   <= 1'b1;
        out_data <= store[i_addr];
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_v    <= 1'b0;
      h_kind <= '0;
      h_addr <= '0;
      h_src  <= '0;
      h_data <= '0;
    end else if (in_park) begin
      h_v    <= 1'b1;
      h_kind <= in_type[1:0];
      h_addr <= in_addr;
      h_src  <= in_src;
      h_data <= in_data;
    end else if (hold_go) begin
      h_v <= 1'b0;
    end
  end

  p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_type[1:0] != 2'b11);
  p_ordered_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_type[2]);
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid || out_seq == $past(out_seq) + 1'b1));
  p_wb_nodata_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_type[1:0] == K_WB) |-> (!out_dv && out_data == '0));
  p_return_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_ret) |-> pend[in_addr]);
  p_hold_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (h_v && pend[h_addr]) |=> h_v);
  p_ret_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_ret) |-> in_ready);
  p_hold_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_v && in_valid && !is_ret) |-> !in_ready);
  p_stall_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid &&
      $stable({out_type, out_addr, out_src, out_seq, out_dv, out_data})));
endmodule

// File: tb/ring_home_ctrl_test.sv
`timescale 1ns/1ps
module ring_home_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [2:0] in_type = '0;
  logic [3:0] in_addr = '0;
  logic [2:0] in_src = '0;
  logic [15:0] in_data = '0;
  logic out_valid, out_ready = 1'b0;
  logic [2:0] out_type;
  logic [3:0] out_addr;
  logic [2:0] out_src;
  logic [7:0] out_seq;
  logic out_dv;
  logic [15:0] out_data;

  ring_home_ctrl uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_type(in_type), .in_addr(in_addr), .in_src(in_src), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type), .out_addr(out_addr),
    .out_src(out_src), .out_seq(out_seq), .out_dv(out_dv), .out_data(out_data));

  always #2 clk = ~clk;

  typedef struct { int kind; int addr; int src; int data; int due; } msg_t;
  msg_t rq[$];
  msg_t rt[$];

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  int unsigned rs = 32'h1234_5678;

  int m_mem[16];
  bit m_own[16], m_pend[16];
  bit hv; msg_t hm;
  bit ov; int o_kind, o_addr, o_src, o_seq, o_dv, o_data;
  int seq = 0;
  bit prev_stall = 0;
  bit off_ret;

  function automatic int unsigned rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic push(input int k, input int a, input int s, input int d);
    msg_t m; m.kind = k; m.addr = a; m.src = s; m.data = d; m.due = 0;
    rq.push_back(m);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic compare_out();
    string t;
    t = (cyc < 2) ? "R1" : (prev_stall ? "R9" : "");
    chk(out_valid == ov, t == "" ? "R7" : t, "out_valid", out_valid, ov);
    if (ov && out_valid) begin
      chk(out_type == 3'(4 + o_kind), t == "" ? "R2" : t, "out_type", out_type, 4 + o_kind);
      chk(out_addr == 4'(o_addr), t == "" ? "R2" : t, "out_addr", out_addr, o_addr);
      chk(out_src == 3'(o_src), t == "" ? "R2" : t, "out_src", out_src, o_src);
      chk(out_seq == 8'(o_seq), t == "" ? "R2" : t, "out_seq", out_seq, o_seq);
      chk(out_dv == o_dv[0], t != "" ? t : (o_kind == 2 ? "R6" : (o_dv != 0 ? "R3" : "R4 R5")),
          "out_dv", out_dv, o_dv);
      chk(out_data == 16'(o_data), t != "" ? t : (o_kind == 2 ? "R6" : "R3"),
          "out_data", out_data, o_data);
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    bit slot, is_ret, hold_go, in_go, in_park, exp_rdy, issue;
    msg_t cur, im;
    int idle;
    for (int i = 0; i < 16; i++) begin m_mem[i] = 0; m_own[i] = 0; m_pend[i] = 0; end
    hv = 0; ov = 0;
    // R1 reset read returns zero, R6 write-back then read, R5 exclusive then shared, R7 conflicts
    push(0, 1, 0, 0); push(2, 1, 1, 16'h1234); push(0, 1, 2, 0);
    push(1, 2, 3, 0); push(0, 2, 0, 0); push(1, 2, 1, 0); push(2, 2, 1, 16'hBEEF); push(0, 2, 2, 0);
    for (int i = 0; i < 1500; i++) begin
      int unsigned r = rnd();
      push(int'(r % 3), (i < 800) ? int'((r >> 4) % 4) : int'((r >> 4) % 16),
           int'((r >> 8) % 8), int'((r >> 12) & 16'hFFFF));
    end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    idle = 0;
    while (!done) begin
      @(negedge clk);
      compare_out();
      if (rq.size() == 0 && rt.size() == 0 && !hv && !ov) break;
      idle = (ov || rq.size() != 0) ? idle + 1 : 0;
      if (ov && out_ready && out_valid) idle = 0;
      if (idle > 2000) begin
        chk(0, "R7", "no progress", idle, 0);
        break;
      end
      out_ready = (rnd() % 4) != 0;
      off_ret = 0;
      if (rt.size() != 0 && rt[0].due <= cyc) begin
        cur = rt[0]; off_ret = 1;
        in_valid = 1; in_type = 3'(4 + cur.kind); in_data = 16'(rnd());
      end else if (rq.size() != 0) begin
        cur = rq[0];
        in_valid = 1; in_type = 3'(cur.kind); in_data = 16'(cur.data);
      end else begin
        in_valid = 0;
      end
      if (in_valid) begin in_addr = 4'(cur.addr); in_src = 3'(cur.src); end
      #1;
      slot = !ov || out_ready;
      is_ret = off_ret;
      hold_go = hv && !m_pend[hm.addr] && slot;
      in_go = in_valid && !is_ret && !hv && !m_pend[cur.addr] && slot;
      in_park = in_valid && !is_ret && !hv && m_pend[cur.addr];
      exp_rdy = is_ret || (!hv && (m_pend[cur.addr] || slot));
      if (in_valid)
        chk(in_ready == exp_rdy,
            cyc < 2 ? "R1" : (is_ret || hv) ? "R8" : (m_pend[cur.addr] ? "R7" : "R10"),
            "in_ready", in_ready, exp_rdy);
      @(posedge clk);
      prev_stall = ov && !out_ready;
      issue = hold_go || in_go;
      if (ov && out_ready) begin
        msg_t r; r.kind = o_kind; r.addr = o_addr; r.src = o_src; r.data = 0;
        r.due = cyc + 3 + int'(rnd() % 5);
        rt.push_back(r);
      end
      if (in_valid && is_ret) begin m_pend[cur.addr] = 0; void'(rt.pop_front()); end
      if (issue) begin
        im = hold_go ? hm : cur;
        ov = 1; o_kind = im.kind; o_addr = im.addr; o_src = im.src; o_seq = seq % 256;
        seq++;
        if (im.kind == 2) begin
          o_dv = 0; o_data = 0; m_mem[im.addr] = im.data; m_own[im.addr] = 0;
        end else begin
          o_dv = m_own[im.addr] ? 0 : 1;
          o_data = m_own[im.addr] ? 0 : m_mem[im.addr];
          if (im.kind == 1) m_own[im.addr] = 1;
        end
        m_pend[im.addr] = 1;
      end else if (out_ready) begin
        ov = 0;
      end
      if (in_park) begin hv = 1; hm = cur; end
      else if (hold_go) hv = 0;
      if (in_valid && !is_ret && (in_go || in_park)) void'(rq.pop_front());
      cyc++;
    end
    chk(rq.size() == 0 && rt.size() == 0, "R8", "drained", rq.size() + rt.size(), 0);
    finish_run();
  end
endmodule